// File: doc/BRIEF.md
# Serial Clock Output Freeze Controller

This block sits between a bank of free-running clock dividers and the chip's clock outputs. It lets an external controller stop any of twelve divided clocks, or restart it, through a slow two-wire serial port made of a serial clock and a serial data line. The dividers are never stopped. The block only gates what leaves them, so a restarted output comes back on the same phase as its siblings that were never stopped.

A frame on the serial port is a low start bit followed by twelve enable bits. Both lines are sampled on rising edges of the serial clock after they have been brought into the core clock domain. Nothing changes until all twelve bits are in. Each output's gate then picks up its new enable value only in a core cycle where that output's raw clock is low. An output therefore never shows a shortened high pulse. It either passes a whole pulse or none at all.

Top module: `clkfreeze_ctrl`

## Requirements
- R1: While `rst` is high every output is low, and after reset every output is enabled. A reset in the middle of a frame discards the partial frame.
- R2: A frame is a start bit (data low at a rising serial-clock edge while idle) followed by 12 data bits, one per rising serial-clock edge. The k-th data bit (k = 0..11) controls `gated_clk_o[k]`, so the three groups of four land on bits [3:0], [7:4] and [11:8]. A bit value of 1 enables the output and 0 freezes it. Both serial lines idle high.
- R3: A partial frame has no effect on any output. The new enables apply only after the twelfth data bit has arrived.
- R4: A frozen output is held at logic low.
- R5: An enabled output equals its raw clock delayed by exactly one core cycle.
- R6: Every high pulse on an output is a complete high phase of its raw clock. An enable change takes effect only in cycles where that raw clock is low, and no runt pulse is produced.
- R7: When an output is unfrozen it runs in phase with its raw clock and with the outputs that stayed enabled, because the dividers keep counting while it is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the raw clocks are synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| frz_sclk_i | input | 1 | Serial control clock, asynchronous, idles high |
| frz_sdat_i | input | 1 | Serial control data, asynchronous, idles high |
| raw_clk_i | input | 12 | Divided clocks from the divider bank |
| gated_clk_o | output | 12 | Registered, gated clock outputs |

## Verification
The assertions check three things on every cycle. Each output is low during reset. A high output always follows a high raw clock in the previous cycle. An output only falls after its raw clock has gone low. They also check that the active enable word changes only on a completed frame. The bench scenarios are needed for the rest: the bit order of a frame, that a partial frame leaves the outputs alone, that a reset in the middle of a frame returns everything to enabled, and that every observed high pulse has the full length of its divider's high phase across freeze and unfreeze events.

// File: rtl/clkfreeze_pkg.sv
package clkfreeze_pkg;
  typedef enum logic [0:0] {
    RX_IDLE = 1'b0,
    RX_DATA = 1'b1
  } rx_state_e;
endpackage

// File: rtl/cf_sync.sv
// Multi-stage level synchronizer into the core clock domain.
module cf_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cf_mask_rx.sv
// Serial frame receiver: start bit then N enable bits, first bit -> index 0.
module cf_mask_rx
  import clkfreeze_pkg::*;
#(
  parameter int N      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_i,
  input  logic         sdat_i,
  output logic [N-1:0] mask_o,
  output logic         load_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic sclk_s, sdat_s, sclk_d, sclk_rise;
  rx_state_e    state_q;
  logic [CW-1:0] idx_q;
  logic [N-1:0] shift_q, mask_q, frame_nxt;
  logic         load_q;

  cf_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync_clk (
    .clk(clk), .rst(rst), .d_i(sclk_i), .q_o(sclk_s));
  cf_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync_dat (
    .clk(clk), .rst(rst), .d_i(sdat_i), .q_o(sdat_s));

  assign sclk_rise = sclk_s & ~sclk_d;

  always_comb begin
    frame_nxt        = shift_q;
    frame_nxt[idx_q] = sdat_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b1;
      state_q <= RX_IDLE;
      idx_q   <= '0;
      shift_q <= '0;
      mask_q  <= '1;
      load_q  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      load_q <= 1'b0;
      if (sclk_rise) begin
        case (state_q)
          RX_IDLE: begin
            if (!sdat_s) begin
              state_q <= RX_DATA;
              idx_q   <= '0;
            end
          end
          RX_DATA: begin
            shift_q <= frame_nxt;
            if (idx_q == LAST) begin
              mask_q  <= frame_nxt;
              load_q  <= 1'b1;
              state_q <= RX_IDLE;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign mask_o = mask_q;
  assign load_o = load_q;
endmodule

// File: rtl/cf_gate_bank.sv
// Per-output gate that only follows the enable while its raw clock is low.
module cf_gate_bank #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] out_o
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    logic gate_q;
    logic out_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        gate_q <= 1'b1;
        out_q  <= 1'b0;
      end else begin
        if (!raw_i[g]) gate_q <= mask_i[g];
        out_q <= raw_i[g] & gate_q;
      end
    end

    assign out_o[g] = out_q;
  end
endmodule

// File: rtl/clkfreeze_ctrl.sv
module clkfreeze_ctrl #(
  parameter int N_OUT       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frz_sclk_i,
  input  logic             frz_sdat_i,
  input  logic [N_OUT-1:0] raw_clk_i,
  output logic [N_OUT-1:0] gated_clk_o
);
  logic [N_OUT-1:0] active_mask;
  logic             mask_load;

  cf_mask_rx #(.N(N_OUT), .STAGES(SYNC_STAGES)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .sclk_i (frz_sclk_i),
    .sdat_i (frz_sdat_i),
    .mask_o (active_mask),
    .load_o (mask_load)
  );

  cf_gate_bank #(.N(N_OUT)) u_gates (
    .clk    (clk),
    .rst    (rst),
    .raw_i  (raw_clk_i),
    .mask_i (active_mask),
    .out_o  (gated_clk_o)
  );
endmodule

// File: rtl/clkfreeze_ctrl_chk.sv
module clkfreeze_ctrl_chk #(
  parameter int N = 12
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] raw,
  input logic [N-1:0] gated,
  input logic [N-1:0] mask,
  input logic         load
);
  // R1: outputs are low one cycle into reset
  a_r1_reset_low: assert property (@(posedge clk) rst |=> (gated == '0));

  // R3: active enables change only on a completed frame
  a_r3_mask_on_frame: assert property (@(posedge clk) disable iff (rst)
    !load |-> $stable(mask));

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R5: a high output needs a high raw clock one cycle earlier
    a_r5_high_follows_raw: assert property (@(posedge clk) disable iff (rst)
      gated[i] |-> $past(raw[i]));
    // R6: an output only drops after its raw clock went low
    a_r6_fall_on_raw_low: assert property (@(posedge clk) disable iff (rst)
      $fell(gated[i]) |-> !$past(raw[i]));
  end
endmodule

bind clkfreeze_ctrl clkfreeze_ctrl_chk #(.N(N_OUT)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .raw   (raw_clk_i),
  .gated (gated_clk_o),
  .mask  (active_mask),
  .load  (mask_load)
);

// File: tb/clkfreeze_ctrl_test.sv
module clkfreeze_ctrl_test;
  localparam int N    = 12;
  localparam int HALF = 4;
  localparam int DIV [N] = '{4, 6, 8, 12, 4, 6, 8, 10, 2, 4, 6, 8};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sclk = 1'b1;
  logic         sdat = 1'b1;
  logic [N-1:0] raw;
  logic [N-1:0] gated;

  int tot = 0;
  int bad = 0;
  int cnt = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  always #10 clk = ~clk;

  clkfreeze_ctrl uut (
    .clk(clk), .rst(rst), .frz_sclk_i(sclk), .frz_sdat_i(sdat),
    .raw_clk_i(raw), .gated_clk_o(gated));

  // free-running divider model, updated away from the active edge
  always @(negedge clk) cnt <= cnt + 1;
  always_comb
    for (int i = 0; i < N; i++) raw[i] = ((cnt % DIV[i]) < DIV[i] / 2);

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    tot++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // R6: every completed high pulse must last a whole raw high phase
  int  run [N];
  bit  seen [N];
  logic [N-1:0] prevg = '0;
  always @(posedge clk) begin
    #5;
    for (int i = 0; i < N; i++) begin
      if (!mon_on) seen[i] = 1'b0;
      else if (gated[i] && !prevg[i]) begin run[i] = 1; seen[i] = 1'b1; end
      else if (gated[i]) run[i]++;
      else if (prevg[i] && seen[i])
        chk(run[i] == DIV[i] / 2, "R6 pulse length", N'(run[i]), N'(DIV[i] / 2));
    end
    prevg = gated;
  end

  task automatic check_window(input logic [N-1:0] en, input int n, input string tag);
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #5;
      chk(gated === (raw & en), tag, gated, raw & en);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sclk = 1'b0; sdat = b;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_part(input logic [N-1:0] m, input int from, input int to,
                           input bit with_start);
    if (with_start) send_bit(1'b0);
    for (int k = from; k <= to; k++) send_bit(m[k]);
    sdat = 1'b1;
  endtask

  task automatic settle();
    repeat (24) @(posedge clk);
  endtask

  task automatic t_reset();
    mon_on = 1'b0;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk); #5;
    chk(gated == '0, "R1 low in reset", gated, '0);
    @(negedge clk); rst = 1'b0;
    settle();
    mon_on = 1'b1;
    check_window('1, 30, "R1 enabled after reset");
  endtask

  task automatic t_pattern(input logic [N-1:0] m, input int skew);
    repeat (skew) @(negedge clk);
    send_part(m, 0, N - 1, 1'b1);
    settle();
    check_window(m, 40, "R4 R5 frozen low, enabled follows raw");
  endtask

  task automatic t_bit_order();
    send_part(12'h001, 0, N - 1, 1'b1);
    settle();
    check_window(12'h001, 30, "R2 first data bit drives output 0");
    send_part(12'h800, 0, N - 1, 1'b1);
    settle();
    check_window(12'h800, 30, "R2 last data bit drives output 11");
    send_part(12'h0F0, 0, N - 1, 1'b1);
    settle();
    check_window(12'h0F0, 30, "R2 middle group on bits 7:4");
  endtask

  task automatic t_partial();
    send_part(12'hFFF, 0, N - 1, 1'b1);
    settle();
    send_part(12'h2A6, 0, 4, 1'b1);
    settle();
    check_window(12'hFFF, 30, "R3 partial frame ignored");
    send_part(12'h2A6, 5, N - 1, 1'b0);
    settle();
    check_window(12'h2A6, 30, "R3 applied after twelfth bit");
  endtask

  task automatic t_unfreeze_phase();
    send_part(12'h000, 0, N - 1, 1'b1);
    settle();
    check_window(12'h000, 20, "R4 all frozen");
    repeat (7) @(negedge clk);
    send_part(12'hFFF, 0, N - 1, 1'b1);
    settle();
    check_window(12'hFFF, 40, "R7 unfrozen in phase with raw");
  endtask

  task automatic t_reset_midframe();
    send_part(12'h000, 0, N - 1, 1'b1);
    settle();
    send_part(12'h000, 0, 6, 1'b1);
    t_reset();
    check_window('1, 10, "R1 partial frame dropped by reset");
    send_part(12'h5A3, 0, N - 1, 1'b1);
    settle();
    check_window(12'h5A3, 30, "R1 R2 clean frame after reset");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tot++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", tot, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pattern(12'hA5C, 0);
    t_pattern(12'h3C9, 3);
    t_pattern(12'h000, 5);
    t_pattern(12'hFFF, 1);
    t_pattern(12'h6E1, 2);
    t_bit_order();
    t_partial();
    t_unfreeze_phase();
    t_reset_midframe();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end
endmodule